// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block drives the initiator side of a paged, indirect register window. A client hands it one request: an 8-bit page, an 8-bit register offset, an access width, a read/write flag and up to 64 bits of write data. The sequencer turns that request into a series of 16-bit management register transactions. All of them go to one fixed device address on a simple command/response port, which stands in for a serial management bus master.

It keeps a copy of the page it last selected, so a page-select transaction is only issued when the page changes. On writes it scatters the data into the data window before issuing the command. On reads it issues the command first and gathers the data window afterwards. In both cases it polls the command register until the operation bits clear. The number of polls is bounded, and a programmable idle gap separates them. The result comes back as a one-cycle done pulse that carries the read data and an error flag.

Top module: `paged_access_engine`

## Requirements
- R1: After reset, reqReady is 1, cmdValid is 0 and doneValid is 0.
- R2: A page-select write goes to offset 0x10 with data {page, 7'b0, 1'b1}, and it is the first transaction of a request. It is issued only when the page cache is invalid or holds a different page. The cache is invalid after reset, so the first request selects its page even when that page is 0xFF.
- R3: The command is a write to offset 0x11 with data {register, 6'b0, read, write}. Bit 1 requests a read and bit 0 requests a write.
- R4: On a write, data words k = 0..n-1 go to offsets 0x18+k in ascending order, all before the command. Word k is bits 16k+15:16k of the write data. For an 8-bit access the upper byte of word 0 is zero. The width code maps to n as follows: 0 (8-bit) gives 1, 1 (16-bit) gives 1, 2 (32-bit) gives 2, 3 (48-bit) gives 3, and 4 (64-bit) gives 4.
- R5: On a read, offsets 0x18+k are read only after completion. Word k lands in doneRdata bits 16k+15:16k. Bits above the access width are zero, and an 8-bit read keeps only the low byte of word 0.
- R6: After the command, offset 0x11 is read back. The operation is complete when bits 1:0 read 0. At most MAX_POLLS (5) polls are made, and a request still busy after the last poll ends with doneErr.
- R7: After a busy poll, cmdValid stays low for at least pollGap cycles before the next poll. No gap follows the final poll.
- R8: An error response ends the request at once: no further command, and doneErr is set. The page cache is left alone, except that a failed page-select write invalidates it, so the next request selects its page again.
- R9: reqReady is high only while idle, and a request is taken on reqValid && reqReady. doneValid is a one-cycle pulse, and doneErr and doneRdata are valid with it.
- R10: Every command carries cmdPhy = PHY_ADDR. cmdValid and the command fields stay stable until cmdReady, and only one command is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request accepted |
| reqPage | input | 8 | Target page |
| reqReg | input | 8 | Register offset within page |
| reqWidth | input | 3 | Width code 0..4 = 8/16/32/48/64 bits |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 64 | Write data, least significant word first |
| pollGap | input | 16 | Idle cycles between completion polls |
| cmdValid | output | 1 | Management command present |
| cmdReady | input | 1 | Command accepted |
| cmdWrite | output | 1 | 1 = register write, 0 = register read |
| cmdPhy | output | 5 | Fixed device address |
| cmdAddr | output | 5 | Management register offset |
| cmdWdata | output | 16 | Management write data |
| rspValid | input | 1 | Response pulse for the outstanding command |
| rspErr | input | 1 | Command failed |
| rspRdata | input | 16 | Read data of the response |
| doneValid | output | 1 | Request finished (one cycle) |
| doneErr | output | 1 | Request failed or timed out |
| doneRdata | output | 64 | Gathered read data |

## Verification
Requests cover all five widths in both directions. Runs of same-page and changing-page requests show whether the page cache suppresses or issues the select write. Busy counts of 0, 1, 2, 4 and 5 separate completion on the first poll, completion after gaps, completion on the last allowed poll, and timeout. Error responses are injected on the page write, on a middle data write and on a poll, which shows where aborts happen and what they do to the cache. The responder stalls cmdReady in a fixed pattern so that held commands are exercised.

// File: rtl/pae_pkg.sv
package pae_pkg;
  localparam logic [4:0] OFS_PAGE = 5'h10;
  localparam logic [4:0] OFS_CMD  = 5'h11;
  localparam logic [4:0] OFS_DATA = 5'h18;

  typedef enum logic [2:0] {PH_PAGE, PH_WDATA, PH_CMD, PH_POLL, PH_RDATA} phase_e;

  // control -> datapath strobes
  typedef struct packed {
    phase_e phase;
    logic   capture, idxClr, idxInc, pageCommit, pageInval;
    logic   pollClr, pollInc, gapLoad, gapDec, rdStore;
  } strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic pageHit, lastWord, pollLast, gapZero, opBusy, isWrite;
  } status_t;

  function automatic logic [2:0] wordsFor(input logic [2:0] code);
    case (code)
      3'd0, 3'd1: return 3'd1;
      3'd2:       return 3'd2;
      3'd3:       return 3'd3;
      default:    return 3'd4;
    endcase
  endfunction

  function automatic logic [63:0] widthMask(input logic [2:0] code);
    case (code)
      3'd0:    return 64'h0000_0000_0000_00FF;
      3'd1:    return 64'h0000_0000_0000_FFFF;
      3'd2:    return 64'h0000_0000_FFFF_FFFF;
      3'd3:    return 64'h0000_FFFF_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/pae_dpath.sv
module pae_dpath
  import pae_pkg::*;
#(
  parameter int MAX_POLLS = 5,
  parameter int GAP_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [7:0]        reqPage,
  input  logic [7:0]        reqReg,
  input  logic [2:0]        reqWidth,
  input  logic              reqWrite,
  input  logic [63:0]       reqWdata,
  input  logic [GAP_W-1:0]  pollGap,
  input  logic [15:0]       rspRdata,
  output status_t           sts,
  output logic              cmdWrite,
  output logic [4:0]        cmdAddr,
  output logic [15:0]       cmdWdata,
  output logic [63:0]       doneRdata
);
  localparam int PC_W = $clog2(MAX_POLLS + 1);

  logic [7:0]       pgQ, rgQ, cachePg;
  logic             cacheVld, wrQ;
  logic [2:0]       widthQ, nWords;
  logic [63:0]      wdataQ, rdAcc;
  logic [1:0]       idx;
  logic [PC_W-1:0]  pollCnt;
  logic [GAP_W-1:0] gapCnt;

  assign nWords = wordsFor(widthQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgQ <= '0; rgQ <= '0; wrQ <= 1'b0; widthQ <= '0;
      wdataQ <= '0; rdAcc <= '0; idx <= '0; pollCnt <= '0; gapCnt <= '0;
      cachePg <= 8'hFF; cacheVld <= 1'b0;
    end else begin
      if (ctl.capture) begin
        pgQ <= reqPage; rgQ <= reqReg; wrQ <= reqWrite; widthQ <= reqWidth;
        wdataQ <= reqWdata & widthMask(reqWidth);
        rdAcc <= '0;
      end
      if (ctl.idxClr)      idx <= '0;
      else if (ctl.idxInc) idx <= idx + 2'd1;
      if (ctl.pageCommit) begin
        cachePg <= pgQ; cacheVld <= 1'b1;
      end else if (ctl.pageInval) begin
        cachePg <= 8'hFF; cacheVld <= 1'b0;
      end
      if (ctl.pollClr)      pollCnt <= '0;
      else if (ctl.pollInc) pollCnt <= pollCnt + 1'b1;
      if (ctl.gapLoad)     gapCnt <= pollGap;
      else if (ctl.gapDec) gapCnt <= gapCnt - 1'b1;
      if (ctl.rdStore)
        rdAcc[{idx, 4'b0} +: 16] <= rspRdata & ((widthQ == 3'd0) ? 16'h00FF : 16'hFFFF);
    end
  end

  always_comb begin
    sts.pageHit  = cacheVld && (cachePg == pgQ);
    sts.lastWord = ({1'b0, idx} + 3'd1) == nWords;
    sts.pollLast = pollCnt == PC_W'(MAX_POLLS - 1);
    sts.gapZero  = gapCnt == '0;
    sts.opBusy   = |rspRdata[1:0];
    sts.isWrite  = wrQ;
  end

  always_comb begin
    cmdWrite = 1'b1;
    cmdAddr  = OFS_CMD;
    cmdWdata = '0;
    case (ctl.phase)
      PH_PAGE:  begin cmdAddr = OFS_PAGE; cmdWdata = {pgQ, 7'b0, 1'b1}; end
      PH_WDATA: begin cmdAddr = OFS_DATA + {3'b0, idx}; cmdWdata = wdataQ[{idx, 4'b0} +: 16]; end
      PH_CMD:   begin cmdWdata = {rgQ, 6'b0, ~wrQ, wrQ}; end
      PH_POLL:  begin cmdWrite = 1'b0; end
      PH_RDATA: begin cmdWrite = 1'b0; cmdAddr = OFS_DATA + {3'b0, idx}; end
      default:  ;
    endcase
  end

  assign doneRdata = rdAcc;

  // R6: busy poll counter never reaches the limit
  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PC_W'(MAX_POLLS));
  // R2: a committed page is seen as a hit afterwards
  p_cache_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pageCommit |=> sts.pageHit);
endmodule

// File: rtl/pae_ctrl.sv
module pae_ctrl
  import pae_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    cmdReady,
  input  logic    rspValid,
  input  logic    rspErr,
  input  status_t sts,
  output logic    reqReady,
  output logic    cmdValid,
  output logic    doneValid,
  output logic    doneErr,
  output strobe_t ctl
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_ISSUE, S_WAIT, S_GAP, S_FIN} state_e;

  state_e state, nState;
  phase_e phaseQ, nPhase;
  logic   errQ, nErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; phaseQ <= PH_PAGE; errQ <= 1'b0;
    end else begin
      state <= nState; phaseQ <= nPhase; errQ <= nErr;
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.phase = phaseQ;
    nState    = state;
    nPhase    = phaseQ;
    nErr      = errQ;
    reqReady  = (state == S_IDLE);
    cmdValid  = (state == S_ISSUE);
    doneValid = (state == S_FIN);
    doneErr   = errQ;
    case (state)
      S_IDLE: if (reqValid) begin
        ctl.capture = 1'b1; nErr = 1'b0; nState = S_START;
      end
      S_START: begin
        ctl.idxClr = 1'b1; nState = S_ISSUE;
        if (!sts.pageHit)     nPhase = PH_PAGE;
        else if (sts.isWrite) nPhase = PH_WDATA;
        else                  nPhase = PH_CMD;
      end
      S_ISSUE: if (cmdReady) nState = S_WAIT;
      S_WAIT: if (rspValid) begin
        if (rspErr) begin
          nErr = 1'b1; nState = S_FIN;
          ctl.pageInval = (phaseQ == PH_PAGE);
        end else begin
          nState = S_ISSUE;
          case (phaseQ)
            PH_PAGE: begin
              ctl.pageCommit = 1'b1; ctl.idxClr = 1'b1;
              nPhase = sts.isWrite ? PH_WDATA : PH_CMD;
            end
            PH_WDATA: if (sts.lastWord) nPhase = PH_CMD; else ctl.idxInc = 1'b1;
            PH_CMD: begin ctl.pollClr = 1'b1; nPhase = PH_POLL; end
            PH_POLL:
              if (!sts.opBusy) begin
                if (sts.isWrite) nState = S_FIN;
                else begin nPhase = PH_RDATA; ctl.idxClr = 1'b1; end
              end else if (sts.pollLast) begin
                nErr = 1'b1; nState = S_FIN;
              end else begin
                ctl.pollInc = 1'b1; ctl.gapLoad = 1'b1; nState = S_GAP;
              end
            PH_RDATA: begin
              ctl.rdStore = 1'b1;
              if (sts.lastWord) nState = S_FIN; else ctl.idxInc = 1'b1;
            end
            default: nState = S_FIN;
          endcase
        end
      end
      S_GAP: if (sts.gapZero) nState = S_ISSUE; else ctl.gapDec = 1'b1;
      S_FIN: nState = S_IDLE;
      default: nState = S_IDLE;
    endcase
  end

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  // R9: one request at a time
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);
  // R10: no new command while a response is arriving
  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !cmdValid);
endmodule

// File: rtl/paged_access_engine.sv
module paged_access_engine
  import pae_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR  = 5'h1E,
  parameter int         MAX_POLLS = 5,
  parameter int         GAP_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [7:0]       reqPage,
  input  logic [7:0]       reqReg,
  input  logic [2:0]       reqWidth,
  input  logic             reqWrite,
  input  logic [63:0]      reqWdata,
  input  logic [GAP_W-1:0] pollGap,
  output logic             cmdValid,
  input  logic             cmdReady,
  output logic             cmdWrite,
  output logic [4:0]       cmdPhy,
  output logic [4:0]       cmdAddr,
  output logic [15:0]      cmdWdata,
  input  logic             rspValid,
  input  logic             rspErr,
  input  logic [15:0]      rspRdata,
  output logic             doneValid,
  output logic             doneErr,
  output logic [63:0]      doneRdata
);
  strobe_t ctl;
  status_t sts;

  assign cmdPhy = PHY_ADDR;

  pae_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cmdReady(cmdReady),
    .rspValid(rspValid), .rspErr(rspErr), .sts(sts), .reqReady(reqReady),
    .cmdValid(cmdValid), .doneValid(doneValid), .doneErr(doneErr), .ctl(ctl)
  );

  pae_dpath #(.MAX_POLLS(MAX_POLLS), .GAP_W(GAP_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqPage(reqPage), .reqReg(reqReg),
    .reqWidth(reqWidth), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .pollGap(pollGap), .rspRdata(rspRdata), .sts(sts), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .doneRdata(doneRdata)
  );

  // R10: a stalled command holds its fields
  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdAddr) && $stable(cmdWdata) && $stable(cmdWrite));
endmodule

// File: tb/paged_access_engine_bench.sv
module paged_access_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PHY = 5'h1E;
  localparam logic [15:0] GAP = 16'd4;

  typedef struct packed {
    logic [7:0]  pg;
    logic [7:0]  rg;
    logic [2:0]  wd;
    logic        wr;
    logic [2:0]  busy;
    logic [3:0]  errAt;
    logic [63:0] wdata;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h03, 8'h10, 3'd1, 1'b0, 3'd0, 4'hF, 64'h0},
    '{8'h03, 8'h22, 3'd2, 1'b1, 3'd1, 4'hF, 64'h1111_2222_DEAD_BEEF},
    '{8'h03, 8'h30, 3'd4, 1'b0, 3'd2, 4'hF, 64'h0},
    '{8'h05, 8'h04, 3'd3, 1'b1, 3'd0, 4'hF, 64'h9999_0123_4567_89AB},
    '{8'h05, 8'h08, 3'd0, 1'b0, 3'd0, 4'hF, 64'h0},
    '{8'h05, 8'h0C, 3'd0, 1'b1, 3'd0, 4'hF, 64'h0000_0000_ABCD_EF12},
    '{8'h07, 8'h01, 3'd1, 1'b0, 3'd5, 4'hF, 64'h0},
    '{8'h07, 8'h02, 3'd1, 1'b0, 3'd4, 4'hF, 64'h0},
    '{8'h09, 8'h00, 3'd2, 1'b1, 3'd0, 4'h0, 64'h0000_0000_5555_AAAA},
    '{8'h09, 8'h00, 3'd2, 1'b1, 3'd0, 4'hF, 64'h0000_0000_5555_AAAA},
    '{8'h09, 8'h40, 3'd4, 1'b1, 3'd0, 4'h2, 64'h0102_0304_0506_0708},
    '{8'h09, 8'h41, 3'd1, 1'b0, 3'd0, 4'h1, 64'h0},
    '{8'h09, 8'h42, 3'd1, 1'b0, 3'd0, 4'hF, 64'h0},
    '{8'h0A, 8'h77, 3'd3, 1'b0, 3'd1, 4'hF, 64'h0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0] reqPage = '0, reqReg = '0;
  logic [2:0] reqWidth = '0;
  logic [63:0] reqWdata = '0;
  logic [15:0] pollGap = GAP;
  logic cmdReady = 1'b0, rspValid = 1'b0, rspErr = 1'b0;
  logic [15:0] rspRdata = '0;
  logic reqReady, cmdValid, cmdWrite, doneValid, doneErr;
  logic [4:0] cmdPhy, cmdAddr;
  logic [15:0] cmdWdata;
  logic [63:0] doneRdata;

  paged_access_engine u_paged_access_engine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqPage(reqPage), .reqReg(reqReg), .reqWidth(reqWidth), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .pollGap(pollGap), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdPhy(cmdPhy), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .doneValid(doneValid), .doneErr(doneErr), .doneRdata(doneRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  // responder state and per-request log
  int txN, pageWrN, cmdWrN, orderErr, gapViol, phyErr, doneCyc, lastRspCyc, gapCnt;
  int busyCfg, errAtCfg, busyLeft;
  bit gapWatch, complete, pendRsp, pendErr, pendBusy;
  logic [15:0] lastPage, cmdData, pendData, curPage;
  logic [15:0] wroteWord [4];
  logic [15:0] dreg [4];

  function automatic logic [63:0] farVal(input logic [7:0] p, input logic [7:0] r);
    return {p, r, ~p, ~r, p ^ r, 8'h5A, r + p, 8'hC3};
  endfunction

  function automatic int wordsOf(input logic [2:0] c);
    return (c <= 3'd1) ? 1 : (c == 3'd2) ? 2 : (c == 3'd3) ? 3 : 4;
  endfunction

  function automatic logic [63:0] maskOf(input logic [2:0] c);
    return (c == 3'd0) ? 64'hFF : (c == 3'd1) ? 64'hFFFF : (c == 3'd2) ? 64'hFFFF_FFFF :
           (c == 3'd3) ? 64'hFFFF_FFFF_FFFF : '1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    txN = 0; pageWrN = 0; cmdWrN = 0; orderErr = 0; gapViol = 0; phyErr = 0;
    doneCyc = 0; lastRspCyc = 0; gapWatch = 0; complete = 0;
    lastPage = '0; cmdData = '0;
    for (int k = 0; k < 4; k++) wroteWord[k] = '0;
  endtask

  // behavioural responder: drives at negedge, DUT samples at posedge
  initial begin
    curPage = '0; busyLeft = 0; pendRsp = 0; pendErr = 0; pendBusy = 0; pendData = '0;
    for (int k = 0; k < 4; k++) dreg[k] = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (doneValid) doneCyc = cyc;
      if (gapWatch) begin
        if (cmdValid) begin
          if (gapCnt < int'(pollGap)) gapViol++;
          gapWatch = 0;
        end else gapCnt++;
      end
      rspValid = 1'b0; rspErr = 1'b0;
      if (pendRsp) begin
        rspValid = 1'b1; rspErr = pendErr; rspRdata = pendData;
        pendRsp = 0; lastRspCyc = cyc;
        if (pendBusy) begin gapWatch = 1; gapCnt = 0; end
      end
      cmdReady = (cyc % 3) != 0;
      if (rstN && cmdValid && cmdReady) begin
        automatic bit err = (txN == errAtCfg);
        automatic logic [15:0] d = '0;
        txN++;
        pendBusy = 0;
        if (cmdPhy !== PHY) phyErr++;
        if (cmdWrite) begin
          if (cmdAddr == 5'h10) begin
            pageWrN++; lastPage = cmdWdata;
            if (!err) curPage = cmdWdata;
          end else if (cmdAddr >= 5'h18 && cmdAddr <= 5'h1B) begin
            if (cmdWrN > 0) orderErr++;
            wroteWord[cmdAddr - 5'h18] = cmdWdata;
          end else if (cmdAddr == 5'h11) begin
            cmdWrN++; cmdData = cmdWdata; busyLeft = busyCfg; complete = 0;
            if (cmdWdata[1] && !err) begin
              automatic logic [63:0] fv = farVal(curPage[15:8], cmdWdata[15:8]);
              for (int k = 0; k < 4; k++) dreg[k] = fv[16*k +: 16];
            end
          end
        end else begin
          if (cmdAddr == 5'h11) begin
            if (busyLeft > 0) begin d = cmdData; busyLeft--; pendBusy = !err; end
            else begin d = cmdData & 16'hFFFC; complete = 1; end
          end else if (cmdAddr >= 5'h18 && cmdAddr <= 5'h1B) begin
            if (!complete) orderErr++;
            d = dreg[cmdAddr - 5'h18];
          end
        end
        pendData = d; pendErr = err; pendRsp = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  bit gotDone;
  logic gotErr;
  logic [63:0] gotData;

  task automatic runReq(input vec_t v);
    clearLog();
    busyCfg = int'(v.busy); errAtCfg = (v.errAt == 4'hF) ? 99 : int'(v.errAt);
    @(negedge clk);
    reqValid = 1'b1; reqPage = v.pg; reqReg = v.rg; reqWidth = v.wd;
    reqWrite = v.wr; reqWdata = v.wdata;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 reqReady low after accept", {63'b0, reqReady}, 64'd0);
    gotDone = 0;
    for (int w = 0; w < 3000 && !gotDone; w++) begin
      if (doneValid) begin gotDone = 1; gotErr = doneErr; gotData = doneRdata; end
      else @(negedge clk);
    end
    chk("R9 done seen", {63'b0, gotDone}, 64'd1);
    @(negedge clk);
    chk("R9 done single pulse", {63'b0, doneValid}, 64'd0);
  endtask

  bit mVld;
  logic [7:0] mPg;

  initial begin
    pollGap = GAP;
    clearLog(); busyCfg = 0; errAtCfg = 99;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reqReady", {63'b0, reqReady}, 64'd1);
    chk("R1 cmdValid", {63'b0, cmdValid}, 64'd0);
    chk("R1 doneValid", {63'b0, doneValid}, 64'd0);
    mVld = 0; mPg = 8'hFF;

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic int nw = wordsOf(v.wd);
      automatic int pg = (!mVld || mPg != v.pg) ? 1 : 0;
      automatic int cmdIdx = pg + (v.wr ? nw : 0);
      automatic int polls = (v.busy >= 5) ? 5 : int'(v.busy) + 1;
      automatic int len = cmdIdx + 1 + polls + ((!v.wr && v.busy < 5) ? nw : 0);
      automatic int ea = (v.errAt == 4'hF) ? 99 : int'(v.errAt);
      automatic bit inj = ea < len;
      automatic bit expErr = inj || (v.busy >= 5);
      automatic logic [63:0] wm = v.wdata & maskOf(v.wd);
      runReq(v);
      chk($sformatf("R6 R8 doneErr vec%0d", i), {63'b0, gotErr}, {63'b0, expErr});
      chk($sformatf("R8 transaction count vec%0d", i), txN, inj ? ea + 1 : len);
      chk($sformatf("R2 page write count vec%0d", i), pageWrN, pg);
      if (pg == 1) chk($sformatf("R2 page data vec%0d", i), lastPage, {v.pg, 7'b0, 1'b1});
      if (ea >= cmdIdx)
        chk($sformatf("R3 command data vec%0d", i), cmdData, {v.rg, 6'b0, !v.wr, v.wr});
      if (v.wr && ea >= cmdIdx)
        for (int k = 0; k < nw; k++)
          chk($sformatf("R4 data word %0d vec%0d", k, i), wroteWord[k], wm[16*k +: 16]);
      if (!expErr)
        chk($sformatf("R5 read data vec%0d", i), gotData,
            v.wr ? 64'd0 : (farVal(v.pg, v.rg) & maskOf(v.wd)));
      chk($sformatf("R4 R5 ordering vec%0d", i), orderErr, 0);
      chk($sformatf("R7 poll gap vec%0d", i), gapViol, 0);
      chk($sformatf("R10 device address vec%0d", i), phyErr, 0);
      if (v.busy >= 5 && !inj)
        chk("R7 no gap after final poll", {63'b0, (doneCyc - lastRspCyc) <= 2}, 64'd1);
      if (pg == 1) begin
        if (ea == 0) mVld = 0;
        else begin mVld = 1; mPg = v.pg; end
      end
    end

    // directed: after a new reset the cache is invalid, page 0xFF still selected
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 reqReady after second reset", {63'b0, reqReady}, 64'd1);
    runReq('{8'hFF, 8'h01, 3'd1, 1'b0, 3'd0, 4'hF, 64'h0});
    chk("R2 page 0xFF selected after reset", pageWrN, 1);
    chk("R2 page 0xFF data", lastPage, 16'hFF01);
    chk("R5 page 0xFF read", gotData, farVal(8'hFF, 8'h01) & 64'hFFFF);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule